// File: doc/BRIEF.md
# Branch Discontinuity Trace Buffer

This block keeps a short history of where program flow jumped, for use by a debug monitor. Each cycle it may be given the address of an executed instruction. It compares that address with the address executed before it. If the new address is not the previous address plus one, the flow has left straight-line code. The block then stores two addresses as one entry: the address the flow left from and the address it arrived at. Capture keeps pace with the core, so one entry can be written on every cycle.

The entries sit in a small circular store that holds the most recent `DEPTH` jumps, four by default. Once the store is full, each new jump replaces the oldest entry. A combinational read port takes an index and returns one entry. Index 0 is the oldest entry still held, and higher indices give newer ones. A count output tells the reader how many entries are meaningful since reset. While a debug trap is active, capture is frozen, so reading out the history does not change it.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset `rd_count` is 0, and every read index returns a zero pair.
- R2: A valid fetch whose address equals the previous valid fetch address plus one stores nothing.
- R3: A valid fetch whose address differs from the previous valid fetch address plus one stores the pair (previous address as `rd_from`, new address as `rd_to`). The pair and the new count can be read from the cycle after that clock edge.
- R4: The first valid fetch after reset has no predecessor, so it stores nothing.
- R5: `rd_count` rises by one for each stored pair and saturates at `DEPTH` (4).
- R6: When the store is full, a new pair replaces the oldest one. `rd_idx` 0 returns the oldest pair held, and `rd_idx` `rd_count-1` returns the newest.
- R7: While `freeze` is 1, nothing is stored and the previous address is forgotten. The first valid fetch after `freeze` returns to 0 is therefore treated like R4.
- R8: Cycles with `fetch_valid` at 0 change nothing. The next valid fetch is compared with the last valid fetch address.
- R9: Any `rd_idx` at or above `rd_count` returns `rd_from` and `rd_to` as 0.
- R10: The step from the all-ones address to address 0 counts as sequential (the increment wraps at `AW` bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction at `fetch_addr` executes this cycle |
| fetch_addr | input | AW | Address of the executing instruction |
| freeze | input | 1 | Debug trap active; capture is suspended |
| rd_idx | input | clog2(DEPTH) | Readback index, 0 = oldest |
| rd_from | output | AW | Source address of the selected pair |
| rd_to | output | AW | Destination address of the selected pair |
| rd_count | output | clog2(DEPTH+1) | Number of valid pairs, saturating at DEPTH |

## Verification
The hardest case to reach from the ports is a freeze window whose fetches could be mistaken for a jump once the freeze ends. The bench freezes after a stored pair and feeds fetches during the freeze. After release it fetches an address that would be a jump relative to the last address before the freeze, and the count must stay unchanged. The overwrite ordering is reached by storing five jumps in a row. The bench then checks that index 0 has moved on to the second pair.

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          freeze,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_from,
  output logic [AW-1:0] rd_to,
  output logic [CW-1:0] rd_count
);

  logic [AW-1:0] from_mem [DEPTH];
  logic [AW-1:0] to_mem   [DEPTH];
  logic [AW-1:0] last_addr;
  logic          have_last;
  logic [IW-1:0] wr_ptr;
  logic [CW-1:0] count;

  wire          take = fetch_valid && !freeze;
  wire          jump = take && have_last && (fetch_addr != last_addr + AW'(1));
  wire          full = (count == CW'(DEPTH));
  wire [IW-1:0] ptr_nxt = (wr_ptr == IW'(DEPTH - 1)) ? '0 : wr_ptr + IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
      wr_ptr    <= '0;
      count     <= '0;
    end else if (freeze) begin
      have_last <= 1'b0;
    end else if (fetch_valid) begin
      last_addr <= fetch_addr;
      have_last <= 1'b1;
      if (jump) begin
        wr_ptr <= ptr_nxt;
        if (!full) count <= count + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (jump) begin
      from_mem[wr_ptr] <= last_addr;
      to_mem[wr_ptr]   <= fetch_addr;
    end
  end

  logic [IW-1:0] rd_slot;
  logic          rd_hit;

  always_comb begin
    int base;
    int sum;
    base = full ? int'(wr_ptr) : 0;
    sum  = base + int'(rd_idx);
    if (sum >= DEPTH) sum = sum - DEPTH;
    rd_slot = IW'(sum);
    rd_hit  = int'(rd_idx) < int'(count);
  end

  assign rd_from  = rd_hit ? from_mem[rd_slot] : '0;
  assign rd_to    = rd_hit ? to_mem[rd_slot]   : '0;
  assign rd_count = count;

endmodule

module branch_trace_buf_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic          freeze,
  input logic [IW-1:0] rd_idx,
  input logic [AW-1:0] rd_from,
  input logic [AW-1:0] rd_to,
  input logic [CW-1:0] rd_count,
  input logic [AW-1:0] last_addr,
  input logic          have_last,
  input logic [IW-1:0] wr_ptr
);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_count) <= DEPTH);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_count == $past(rd_count) || rd_count == $past(rd_count) + CW'(1)));

  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(rd_count) && $stable(wr_ptr)));

  a_r2_seq_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && have_last && fetch_addr == last_addr + AW'(1)) |=> $stable(wr_ptr));

  a_r4_first_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !have_last |=> $stable(wr_ptr));

  a_r8_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> ($stable(wr_ptr) && $stable(rd_count)));

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= int'(rd_count)) |-> (rd_from == '0 && rd_to == '0));

  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_ptr) < DEPTH);

endmodule

bind branch_trace_buf branch_trace_buf_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .freeze(freeze), .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to),
  .rd_count(rd_count), .last_addr(last_addr), .have_last(have_last), .wr_ptr(wr_ptr)
);

// File: tb/branch_trace_buf_bench.sv
module branch_trace_buf_bench;
  localparam int AW = 16;
  localparam int DEPTH = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          freeze = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [AW-1:0] rd_from, rd_to;
  logic [CW-1:0] rd_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  branch_trace_buf #(.AW(AW), .DEPTH(DEPTH)) u_branch_trace_buf (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .freeze(freeze), .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to),
    .rd_count(rd_count)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; freeze = 1'b0; fetch_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic f);
    fetch_valid = v; fetch_addr = a; freeze = f;
    @(negedge clk);
    fetch_valid = 1'b0; freeze = 1'b0;
  endtask

  task automatic chk_count(input int exp, input string req);
    checks++;
    if (int'(rd_count) != exp) begin
      errors++;
      $display("FAIL %s count actual=%0d expected=%0d", req, rd_count, exp);
    end
  endtask

  task automatic chk_pair(input int idx, input logic [AW-1:0] ef, input logic [AW-1:0] et,
                          input string req);
    rd_idx = IW'(idx);
    #1;
    checks++;
    if (rd_from !== ef || rd_to !== et) begin
      errors++;
      $display("FAIL %s idx=%0d actual=(%h,%h) expected=(%h,%h)", req, idx, rd_from, rd_to, ef, et);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_count(0, "R1");
    chk_pair(0, '0, '0, "R1");
    chk_pair(3, '0, '0, "R1");
  endtask

  task automatic t_sequential();
    do_reset();
    step(1, 16'd10, 0);
    chk_count(0, "R4");
    step(1, 16'd11, 0);
    step(1, 16'd12, 0);
    step(1, 16'd13, 0);
    chk_count(0, "R2");
    step(1, 16'd40, 0);
    chk_count(1, "R3");
    chk_pair(0, 16'd13, 16'd40, "R3");
    step(0, 16'd99, 0);
    step(0, 16'd5, 0);
    step(1, 16'd41, 0);
    chk_count(1, "R8");
    step(1, 16'd7, 0);
    chk_count(2, "R3");
    chk_pair(0, 16'd13, 16'd40, "R6");
    chk_pair(1, 16'd41, 16'd7, "R3");
    chk_pair(2, '0, '0, "R9");
  endtask

  task automatic t_wrap();
    do_reset();
    step(1, 16'd100, 0);
    step(1, 16'd200, 0);
    step(1, 16'd300, 0);
    step(1, 16'd400, 0);
    chk_count(3, "R5");
    step(1, 16'd500, 0);
    chk_count(4, "R5");
    chk_pair(0, 16'd100, 16'd200, "R6");
    step(1, 16'd600, 0);
    chk_count(4, "R5");
    chk_pair(0, 16'd200, 16'd300, "R6");
    chk_pair(3, 16'd500, 16'd600, "R6");
  endtask

  task automatic t_freeze();
    do_reset();
    step(1, 16'd10, 0);
    step(1, 16'd20, 0);
    chk_count(1, "R3");
    step(1, 16'd50, 1);
    step(1, 16'd90, 1);
    chk_count(1, "R7");
    step(1, 16'd60, 0);
    chk_count(1, "R7");
    step(1, 16'd61, 0);
    step(1, 16'd5, 0);
    chk_count(2, "R7");
    chk_pair(1, 16'd61, 16'd5, "R7");
  endtask

  task automatic t_addr_wrap();
    do_reset();
    step(1, 16'hFFFE, 0);
    step(1, 16'hFFFF, 0);
    step(1, 16'h0000, 0);
    chk_count(0, "R10");
    step(1, 16'h0005, 0);
    chk_count(1, "R10");
    chk_pair(0, 16'h0000, 16'h0005, "R10");
    chk_pair(1, '0, '0, "R9");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_wrap();
    t_freeze();
    t_addr_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule